// File: doc/BRIEF.md
# Heartbeat Tag Link Framer

This block carries 64-bit tag records across a synchronous link that is seventeen wires wide: sixteen data lines and one framing flag. Every frame lasts five clocks. Four beats carry the tag, one 16-bit word per beat, and the fifth beat is idle. On the flag wire the frames show as a steady 1,1,1,1,0 beat. The transmitter never pauses. When the user has offered no tag, it sends an all-zero filler frame. Before sending, it puts seven check bits in the low end of the last word, so the receiver can repair any single flipped bit and detect any two flipped bits.

The receiver aligns to the flag pattern, reports whether it holds lock, and pulses a link error when the pattern breaks while locked. It rebuilds each tag, corrects it, and hands real tags (not fillers) to the user with a one-cycle strobe and two status flags. A tag enters as 56 payload bits through a valid/ready handshake and leaves as the same 56 bits.

Top module: `hbt_link_top`

## Requirements
- R1: The flag wire repeats 1,1,1,1,0 from reset without a pause. The data lines carry tag bits 63:48, then 47:32, then 31:16, then 15:0 on the four flagged beats, and all zeros on the idle beat.
- R2: `in_ready` is high only during the idle beat. A tag accepted there goes out in the next frame with tag bit 63 = 1, the payload in bits 62:7 and the check bits in 6:0. With no tag accepted, the frame sent is all zeros.
- R3: The check bits are computed as follows. Data bit i (tag bit 7+i, for i = 0..56) sits at the i-th position from 3 upward that is not a power of two. Bits 5:0 are the XOR of the positions of all set data bits. Bit 6 makes the total count of ones in the 64-bit tag even.
- R4: After reset the receiver aligns on the first flag zero. It raises `link_locked` after the next two complete, correct flag patterns, which is 15 clocks after reset release on a loop-back link.
- R5: While locked, any flag value that does not match the expected beat gives a one-cycle `link_error` pulse and drops `link_locked` in the same cycle. The receiver relocks after two further correct patterns.
- R6: Each received real tag gives exactly one one-cycle `out_valid` with its 56-bit payload. Tags come out in the order they were sent.
- R7: Any single flipped bit among the 64 tag bits is repaired. The tag is delivered with `out_corrected` = 1 and `out_uncorrectable` = 0.
- R8: Any two flipped bits are delivered with `out_uncorrectable` = 1 and `out_corrected` = 0.
- R9: Filler frames produce no `out_valid`.
- R10: No tag is delivered while `link_locked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A tag is offered |
| in_ready | output | 1 | High during the idle beat, when a tag is taken |
| in_payload | input | 56 | Payload of the offered tag |
| link_tx_data | output | 16 | Data lines sent |
| link_tx_flag | output | 1 | Framing flag sent |
| link_rx_data | input | 16 | Data lines received |
| link_rx_flag | input | 1 | Framing flag received |
| out_valid | output | 1 | One-cycle strobe for a received tag |
| out_payload | output | 56 | Payload of the received tag |
| out_corrected | output | 1 | A single-bit error was repaired |
| out_uncorrectable | output | 1 | A double-bit error was detected |
| link_locked | output | 1 | The receiver holds frame alignment |
| link_error | output | 1 | Pulse when the flag pattern breaks while locked |

## Verification
A transmit beat counter in the wrong state shows at the ports within one frame. Either the flag cadence shifts, or a word lands in the wrong slot, which the checks on the transmitted words catch. A wrong receive phase or lock state shows as a lock time that differs from 15 clocks. It also shows as payloads that are lost or delivered outside lock, or as a missing error pulse after a broken flag. A decoder fault shows at the first injected error as a payload that does not match or status flags that are wrong.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
  localparam int WORD_W  = 16;
  localparam int N_WORDS = 4;
  localparam int TAG_W   = WORD_W * N_WORDS;
  localparam int CHK_W   = 7;
  localparam int SYN_W   = CHK_W - 1;
  localparam int DAT_W   = TAG_W - CHK_W;
  localparam int PAY_W   = DAT_W - 1;

  typedef struct packed {
    logic [DAT_W-1:0] data;
    logic             corr;
    logic             unc;
  } hm_res_t;

  // code position of data bit i: i-th non-power-of-two from 3 upward
  function automatic logic [SYN_W-1:0] hm_pos(input int i);
    int n;
    logic [SYN_W-1:0] r;
    n = 0;
    r = '0;
    for (int p = 3; p < (1 << SYN_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == i) r = p[SYN_W-1:0];
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [CHK_W-1:0] hm_check(input logic [DAT_W-1:0] d);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int i = 0; i < DAT_W; i++)
      if (d[i]) s = s ^ hm_pos(i);
    return {(^d) ^ (^s), s};
  endfunction

  function automatic hm_res_t hm_decode(input logic [TAG_W-1:0] t);
    hm_res_t r;
    logic [SYN_W-1:0] s;
    r.data = t[TAG_W-1:CHK_W];
    r.corr = 1'b0;
    r.unc  = 1'b0;
    s = t[SYN_W-1:0];
    for (int i = 0; i < DAT_W; i++)
      if (t[CHK_W+i]) s = s ^ hm_pos(i);
    if (^t) begin
      r.corr = 1'b1;
      for (int i = 0; i < DAT_W; i++)
        if (hm_pos(i) == s) r.data[i] = ~r.data[i];
    end else if (s != '0) begin
      r.unc = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/hbt_tx.sv
module hbt_tx
  import hbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PAY_W-1:0]  in_payload,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_flag
);
  localparam int BEAT_W = $clog2(N_WORDS + 1);
  localparam int IDX_W  = $clog2(N_WORDS);
  localparam logic [BEAT_W-1:0] IDLE_BEAT = BEAT_W'(N_WORDS);

  logic [BEAT_W-1:0] beat_q;
  logic [TAG_W-1:0]  frame_q;
  logic [WORD_W-1:0] words [N_WORDS];
  logic              tx_idle;
  logic              tx_accept;

  assign tx_idle   = (beat_q == IDLE_BEAT);
  assign in_ready  = tx_idle;
  assign tx_accept = tx_idle && in_valid;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_words
    assign words[w] = frame_q[TAG_W-1-WORD_W*w -: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      frame_q <= '0;
    end else begin
      beat_q <= tx_idle ? '0 : beat_q + 1'b1;
      if (tx_idle)
        frame_q <= tx_accept ? {1'b1, in_payload, hm_check({1'b1, in_payload})} : '0;
    end
  end

  assign tx_flag = !tx_idle;
  assign tx_data = tx_idle ? '0 : words[beat_q[IDX_W-1:0]];

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_flag |-> (tx_data == '0));
  p_cadence_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_flag |=> tx_flag);
  p_accept_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> tx_data[WORD_W-1]);
endmodule

// File: rtl/hbt_rx.sv
module hbt_rx
  import hbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_flag,
  output logic              out_valid,
  output logic [PAY_W-1:0]  out_payload,
  output logic              out_corrected,
  output logic              out_uncorrectable,
  output logic              link_locked,
  output logic              link_error
);
  localparam int BEAT_W = $clog2(N_WORDS + 1);
  localparam logic [BEAT_W-1:0] IDLE_BEAT = BEAT_W'(N_WORDS);

  logic              have_q;
  logic              good_q;
  logic [BEAT_W-1:0] ph_q;
  logic [TAG_W-1:0]  sh_q;
  logic              rx_match;
  logic              rx_frame_end;
  hm_res_t           dec;

  assign rx_match     = (rx_flag == (ph_q != IDLE_BEAT));
  assign rx_frame_end = have_q && rx_match && (ph_q == IDLE_BEAT);
  assign dec          = hm_decode(sh_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      good_q <= 1'b0;
      ph_q   <= '0;
      sh_q   <= '0;
      link_locked       <= 1'b0;
      link_error        <= 1'b0;
      out_valid         <= 1'b0;
      out_payload       <= '0;
      out_corrected     <= 1'b0;
      out_uncorrectable <= 1'b0;
    end else begin
      link_error <= 1'b0;
      out_valid  <= 1'b0;
      if (!have_q) begin
        good_q <= 1'b0;
        if (!rx_flag) begin
          have_q <= 1'b1;
          ph_q   <= '0;
        end
      end else if (!rx_match) begin
        have_q      <= !rx_flag;
        ph_q        <= '0;
        good_q      <= 1'b0;
        link_locked <= 1'b0;
        link_error  <= link_locked;
      end else if (!rx_frame_end) begin
        sh_q <= {sh_q[TAG_W-WORD_W-1:0], rx_data};
        ph_q <= ph_q + 1'b1;
      end else begin
        ph_q <= '0;
        if (!good_q) good_q <= 1'b1;
        else         link_locked <= 1'b1;
        if (link_locked && (dec.data[DAT_W-1] || dec.unc)) begin
          out_valid         <= 1'b1;
          out_payload       <= dec.data[PAY_W-1:0];
          out_corrected     <= dec.corr;
          out_uncorrectable <= dec.unc;
        end
      end
    end
  end

  p_err_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    link_error |-> !link_locked);
  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_corrected && out_uncorrectable));
  p_valid_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> link_locked);
endmodule

// File: rtl/hbt_link_top.sv
module hbt_link_top
  import hbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PAY_W-1:0]  in_payload,
  output logic [WORD_W-1:0] link_tx_data,
  output logic              link_tx_flag,
  input  logic [WORD_W-1:0] link_rx_data,
  input  logic              link_rx_flag,
  output logic              out_valid,
  output logic [PAY_W-1:0]  out_payload,
  output logic              out_corrected,
  output logic              out_uncorrectable,
  output logic              link_locked,
  output logic              link_error
);
  hbt_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_payload (in_payload),
    .tx_data    (link_tx_data),
    .tx_flag    (link_tx_flag)
  );

  hbt_rx u_rx (
    .clk               (clk),
    .rst_n             (rst_n),
    .rx_data           (link_rx_data),
    .rx_flag           (link_rx_flag),
    .out_valid         (out_valid),
    .out_payload       (out_payload),
    .out_corrected     (out_corrected),
    .out_uncorrectable (out_uncorrectable),
    .link_locked       (link_locked),
    .link_error        (link_error)
  );
endmodule

// File: tb/hbt_link_top_test.sv
module hbt_link_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [55:0] in_payload = '0;
  logic [15:0] link_tx_data;
  logic        link_tx_flag;
  logic [15:0] dmask = '0;
  logic        fmask = 1'b0;
  logic        out_valid;
  logic [55:0] out_payload;
  logic        out_corrected, out_uncorrectable, link_locked, link_error;

  int errors = 0;
  int checks = 0;
  int unexpected = 0;
  int cad_bad = 0;
  int ccnt = 0;
  bit done = 0;

  typedef struct { logic [55:0] p; logic c; logic u; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  hbt_link_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_payload(in_payload), .link_tx_data(link_tx_data), .link_tx_flag(link_tx_flag),
    .link_rx_data(link_tx_data ^ dmask), .link_rx_flag(link_tx_flag ^ fmask),
    .out_valid(out_valid), .out_payload(out_payload), .out_corrected(out_corrected),
    .out_uncorrectable(out_uncorrectable), .link_locked(link_locked), .link_error(link_error)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3 restated: check bit j is parity over data whose position has bit j set
  function automatic logic [6:0] ref_chk(input logic [56:0] d);
    logic [6:0] c;
    int idx;
    c = '0;
    idx = 0;
    for (int pos = 1; pos < 64; pos++) begin
      if ($countones(pos) != 1) begin
        for (int j = 0; j < 6; j++)
          if (pos[j] && d[idx]) c[j] = ~c[j];
        idx++;
      end
    end
    c[6] = ($countones(d) + $countones(c[5:0])) % 2 == 1;
    return c;
  endfunction

  // cadence monitor, R1
  always @(posedge clk) if (rst_n) ccnt <= ccnt + 1;
  always @(negedge clk) if (rst_n && !done) begin
    if (link_tx_flag != (ccnt % 5 != 4)) cad_bad++;
    if (ccnt % 5 == 4 && link_tx_data != 0) cad_bad++;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && out_valid) begin
    if (q.size() == 0) begin
      unexpected++;
      check(0, "R9/R10 unexpected out_valid", {8'h0, out_payload}, 64'h0);
    end else begin
      exp_t e;
      e = q.pop_front();
      if (e.u) begin
        check(out_uncorrectable == 1 && out_corrected == 0, "R8 double error flags",
              {out_corrected, out_uncorrectable}, {e.c, e.u});
      end else begin
        check(out_payload == e.p, "R6 payload", {8'h0, out_payload}, {8'h0, e.p});
        check(out_corrected == e.c && out_uncorrectable == 0,
              e.c ? "R7 corrected flag" : "R6 clean flags",
              {out_corrected, out_uncorrectable}, {e.c, 1'b0});
      end
    end
  end

  task automatic send(input logic [55:0] p, input logic [63:0] mask, input bit expect_out);
    logic [63:0] w;
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_payload = p;
    e.p = p;
    e.c = ($countones(mask) == 1);
    e.u = ($countones(mask) == 2);
    if (expect_out) q.push_back(e);
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      dmask = mask[63-16*k -: 16];
      w[63-16*k -: 16] = link_tx_data;
    end
    @(negedge clk);
    dmask = '0;
    if (mask == 0) begin
      check(w[63] == 1'b1 && w[62:7] == p, "R2 tag layout", w, {1'b1, p, 7'h0});
      check(w[6:0] == ref_chk(w[63:7]), "R3 check bits", {57'h0, w[6:0]}, {57'h0, ref_chk(w[63:7])});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen_err;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && link_locked == 0 && link_error == 0, "R4 reset state",
          {out_valid, link_locked, link_error}, 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    // R4 lock time
    n = 0;
    while (!link_locked && n < 40) begin
      @(posedge clk); @(negedge clk); n++;
    end
    check(n == 15, "R4 lock cycles", n, 15);

    // R6 clean tags of distinct patterns
    send(56'hFF_FFFF_FFFF_FFFF, 0, 1);
    send(56'h00_0000_0000_0000, 0, 1);
    send(56'hA5_5A5A_A5A5_5AA5, 0, 1);
    send(56'h12_3456_789A_BCDE, 0, 1);
    send(56'h80_0000_0000_0001, 0, 1);
    // R7 single-bit errors: marker, payload, lowest payload bit, check bits
    send(56'h11_2233_4455_6677, 64'h1 << 63, 1);
    send(56'h11_2233_4455_6677, 64'h1 << 62, 1);
    send(56'hDE_ADBE_EF01_2345, 64'h1 << 40, 1);
    send(56'hDE_ADBE_EF01_2345, 64'h1 << 7, 1);
    send(56'h0F_0F0F_0F0F_0F0F, 64'h1 << 6, 1);
    send(56'h0F_0F0F_0F0F_0F0F, 64'h1 << 3, 1);
    send(56'h0F_0F0F_0F0F_0F0F, 64'h1, 1);
    // R8 double-bit errors
    send(56'h33_3333_3333_3333, (64'h1 << 50) | (64'h1 << 20), 1);
    send(56'h44_4444_4444_4444, (64'h1 << 1) | (64'h1 << 2), 1);
    send(56'h55_5555_5555_5555, (64'h1 << 63) | (64'h1 << 0), 1);
    // R9 fillers for a while
    repeat (40) @(negedge clk);
    check(q.size() == 0 && unexpected == 0, "R9 fillers silent", unexpected, 0);

    // R5 break the flag on an idle beat
    while (link_tx_flag) @(negedge clk);
    fmask = 1'b1;
    @(negedge clk);
    fmask = 1'b0;
    check(link_error == 1 && link_locked == 0, "R5 error pulse and unlock",
          {link_error, link_locked}, 2'b10);
    @(negedge clk);
    check(link_error == 0, "R5 error is one cycle", link_error, 0);
    // R10 tag sent while unlocked is dropped
    send(56'h77_7777_7777_7777, 0, 0);
    n = 0;
    seen_err = 0;
    while (!link_locked && n < 40) begin
      @(negedge clk); n++;
    end
    check(link_locked == 1, "R5 relock", link_locked, 1);
    check(unexpected == 0, "R10 no delivery unlocked", unexpected, 0);
    send(56'h98_7654_3210_FEDC, 0, 1);
    repeat (10) @(negedge clk);
    check(q.size() == 0, "R6 all delivered", q.size(), 0);
    check(cad_bad == 0, "R1 cadence and idle zeros", cad_bad, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule